// File: doc/BRIEF.md
# Hierarchical Page-Table Walker (64-bit descriptors)

This block translates a 48-bit virtual address by walking a multi-level page table whose entries are 64-bit descriptors. A request carries the virtual address, the level at which the walk begins, the base address of that level's table, and a granule select. The granule is either 4 KB, with levels 0 to 3, or 64 KB, with levels 1 to 3. The walker then issues one descriptor read per level through a valid/ready read port. It classifies each returned descriptor, which depends on both the level and the granule. A table entry sends the walk one level down. A block or page entry ends it.

On the way down, every table entry can impose limits that bind all deeper levels: no execute, no privileged execute, read-only, no user access, and non-secure. The walker folds these limits into the final result. At the end it reports the output address, the size of the mapped region as an offset width, and the leaf attributes merged with the inherited limits. If the walk cannot produce a mapping, it reports instead a fault code with the level at which the walk stopped. The result is valid for the single cycle in which `doneValid` is high, and the outputs then hold until the next walk finishes.

Top module: `xlat_walker`

## Requirements
- R1: `reqReady` is high only while the walker is idle. A walk issues at most one descriptor read per level, and it holds `memValid` and `memAddr` steady until `memReady`. Each walk ends with `doneValid` high for exactly one cycle.
- R2: For level L the descriptor address is the table base ORed with (VA index << 3). The index field starts at VA bit (G-3)*(3-L)+G and is G-3 bits wide. G is 12 when `reqGran64`=0 (4 KB) and 16 when `reqGran64`=1 (64 KB).
- R3: The descriptor type is decoded from bits [1:0]. The value 01 is a block at levels 1 and 2 for the 4 KB granule and at level 2 only for the 64 KB granule; at any other level it is invalid. The value 11 is a page at level 3 and a table at every other level. The values 00 and 10 are invalid.
- R4: A table entry gives the next table base as descriptor bits [47:G] with the low G bits zero, and the walk continues one level lower.
- R5: `doneSize` is the offset width n. For the 4 KB granule it is 30 for a level-1 block, 21 for a level-2 block and 12 for a page. For the 64 KB granule it is 29 for a block and 16 for a page. `donePa` is descriptor bits [47:n] joined with VA bits [n-1:0].
- R6: The leaf fields are reported as follows: `doneAttr` from bits [4:2], `doneSh` from bits [9:8], `doneContig` from bit 52, and `doneNg` from bit 11. `doneLevel` is the level of the final descriptor.
- R7: Table bits accumulate by OR across every table level of the walk. Bit 60 is ORed into the leaf bit 54 to give `doneXn`, and bit 59 is ORed into the leaf bit 53 to give `donePxn`. Table bit 62 or leaf bit 7 sets `doneRo`. `doneUser` is leaf bit 6, forced low by table bit 61.
- R8: Table bit 63 set at any level forces `doneNs` high. Otherwise `doneNs` is leaf bit 5.
- R9: An invalid entry ends the walk with `doneFault`=1 (translation) and `doneLevel` equal to that entry's level.
- R10: A block or page whose bit 10 is clear ends the walk with `doneFault`=2 (access flag) at its level. `doneFault`=0 marks a successful walk.
- R11: A request for the 64 KB granule with a start level of 0 ends with a translation fault at level 0 and issues no read.
- R12: Limits accumulated in one walk do not carry into the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Walk request present |
| reqReady | output | 1 | Walker idle, request accepted when both high |
| reqVa | input | 48 | Virtual address to translate |
| reqLevel | input | 2 | Starting lookup level |
| reqBase | input | 48 | Base address of the starting table |
| reqGran64 | input | 1 | 1 selects the 64 KB granule, 0 the 4 KB granule |
| memValid | output | 1 | Descriptor read request |
| memReady | input | 1 | Read request accepted |
| memAddr | output | 48 | Descriptor byte address |
| rspValid | input | 1 | Descriptor data returned |
| rspData | input | 64 | Descriptor contents |
| doneValid | output | 1 | Result valid, one cycle per walk |
| donePa | output | 48 | Output physical address |
| doneSize | output | 5 | Offset width of the mapping in bits |
| doneLevel | output | 2 | Level where the walk ended |
| doneFault | output | 2 | 0 none, 1 translation, 2 access flag |
| doneXn | output | 1 | Execute never |
| donePxn | output | 1 | Privileged execute never |
| doneRo | output | 1 | Write not permitted |
| doneUser | output | 1 | User access allowed |
| doneNs | output | 1 | Non-secure target |
| doneNg | output | 1 | Mapping is not global |
| doneAttr | output | 3 | Memory attribute index |
| doneSh | output | 2 | Shareability |
| doneContig | output | 1 | Contiguous hint |

## Verification
The embedded properties hold on every cycle. They cover the read handshake: the request and address stay stable until accepted, and the result pulse lasts one cycle. They also check that a table is never followed from level 3, that every successful result carries one of the five legal offset widths, that inherited limits only grow during a walk, and that an inherited non-secure flag always reaches the result. The directed scenarios cover everything that needs actual descriptor trees. That includes the index placement for each level and granule, the address joining at every leaf size, and the type decode at every illegal level. It also includes the two fault kinds with their levels, the rejected 64 KB start at level 0, and the clearing of limits between walks.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 48;
  localparam int PA_W   = 48;
  localparam int DESC_W = 64;

  typedef enum logic [1:0] {
    KIND_BAD   = 2'd0,
    KIND_BLOCK = 2'd1,
    KIND_PAGE  = 2'd2,
    KIND_TABLE = 2'd3
  } descKind_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_XLAT   = 2'd1,
    FLT_ACCESS = 2'd2
  } fault_t;

  // control -> datapath strobes
  typedef struct packed {
    logic start;   // latch a new request
    logic step;    // descend through a table entry
    logic finish;  // capture leaf result or fault
  } strobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      startBad,
  input  logic      memReady,
  input  logic      rspValid,
  input  descKind_t kind,
  output strobe_t   strb,
  output logic      reqReady,
  output logic      memValid,
  output logic      doneValid
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;
  state_t state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strb.start = 1'b1;
        stateNxt   = startBad ? S_DONE : S_ISSUE;
      end
      S_ISSUE: if (memReady) stateNxt = S_WAIT;
      S_WAIT: if (rspValid) begin
        if (kind == KIND_TABLE) begin
          strb.step = 1'b1;
          stateNxt  = S_ISSUE;
        end else begin
          strb.finish = 1'b1;
          stateNxt    = S_DONE;
        end
      end
      S_DONE: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign reqReady  = (state == S_IDLE);
  assign memValid  = (state == S_ISSUE);
  assign doneValid = (state == S_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);                                   // R1
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid);                       // R1
endmodule

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
#(
  parameter int VAW = VA_W,
  parameter int PAW = PA_W,
  parameter int DW  = DESC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [VAW-1:0]  reqVa,
  input  logic [1:0]      reqLevel,
  input  logic [PAW-1:0]  reqBase,
  input  logic            reqGran64,
  input  logic [DW-1:0]   rspData,
  output logic            startBad,
  output descKind_t       kind,
  output logic [PAW-1:0]  memAddr,
  output logic [PAW-1:0]  donePa,
  output logic [4:0]      doneSize,
  output logic [1:0]      doneLevel,
  output logic [1:0]      doneFault,
  output logic            doneXn,
  output logic            donePxn,
  output logic            doneRo,
  output logic            doneUser,
  output logic            doneNs,
  output logic            doneNg,
  output logic [2:0]      doneAttr,
  output logic [1:0]      doneSh,
  output logic            doneContig
);
  logic [VAW-1:0] vaR;
  logic           gran;
  logic [1:0]     lvl;
  logic           xnAcc, pxnAcc, roAcc, noUserAcc, nsAcc;
  logic [4:0]     offW;
  logic [PAW-1:0] lowMask, leafPa, tblBase, nextAddr;
  logic           unusedDesc;

  assign unusedDesc = ^{rspData[58:55], rspData[51:48]};

  // index of level l, already scaled to a byte offset
  function automatic logic [PAW-1:0] idxOffset(input logic [VAW-1:0] va,
                                               input logic [1:0] l,
                                               input logic g64);
    int g, stride, lo;
    logic [VAW-1:0] sh, mask;
    g      = g64 ? 16 : 12;
    stride = g - 3;
    lo     = stride * (3 - int'(l)) + g;
    sh     = va >> lo;
    mask   = ~({VAW{1'b1}} << stride);
    return PAW'(sh & mask) << 3;
  endfunction

  assign startBad = reqGran64 && (reqLevel == 2'd0);

  // descriptor type depends on level and granule
  always_comb begin
    unique case (rspData[1:0])
      2'b01: begin
        if (gran) kind = (lvl == 2'd2) ? KIND_BLOCK : KIND_BAD;
        else      kind = (lvl == 2'd1 || lvl == 2'd2) ? KIND_BLOCK : KIND_BAD;
      end
      2'b11:   kind = (lvl == 2'd3) ? KIND_PAGE : KIND_TABLE;
      default: kind = KIND_BAD;
    endcase
  end

  always_comb begin
    if (gran)                    offW = (kind == KIND_PAGE) ? 5'd16 : 5'd29;
    else if (kind == KIND_PAGE)  offW = 5'd12;
    else                         offW = (lvl == 2'd1) ? 5'd30 : 5'd21;
  end

  assign lowMask  = ~({PAW{1'b1}} << offW);
  assign leafPa   = (rspData[PAW-1:0] & ~lowMask) | (PAW'(vaR) & lowMask);
  assign tblBase  = rspData[PAW-1:0] & ({PAW{1'b1}} << (gran ? 16 : 12));
  assign nextAddr = tblBase | idxOffset(vaR, 2'(lvl + 2'd1), gran);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaR <= '0; gran <= 1'b0; lvl <= 2'd0; memAddr <= '0;
      xnAcc <= 1'b0; pxnAcc <= 1'b0; roAcc <= 1'b0; noUserAcc <= 1'b0; nsAcc <= 1'b0;
      donePa <= '0; doneSize <= '0; doneLevel <= '0; doneFault <= FLT_NONE;
      doneXn <= 1'b0; donePxn <= 1'b0; doneRo <= 1'b0; doneUser <= 1'b0;
      doneNs <= 1'b0; doneNg <= 1'b0; doneAttr <= '0; doneSh <= '0; doneContig <= 1'b0;
    end else begin
      if (strb.start) begin
        vaR       <= reqVa;
        gran      <= reqGran64;
        lvl       <= reqLevel;
        memAddr   <= reqBase | idxOffset(reqVa, reqLevel, reqGran64);
        xnAcc     <= 1'b0;
        pxnAcc    <= 1'b0;
        roAcc     <= 1'b0;
        noUserAcc <= 1'b0;
        nsAcc     <= 1'b0;
        if (startBad) begin
          doneFault <= FLT_XLAT;
          doneLevel <= reqLevel;
        end
      end
      if (strb.step) begin
        lvl       <= 2'(lvl + 2'd1);
        memAddr   <= nextAddr;
        nsAcc     <= nsAcc     | rspData[63];
        roAcc     <= roAcc     | rspData[62];
        noUserAcc <= noUserAcc | rspData[61];
        xnAcc     <= xnAcc     | rspData[60];
        pxnAcc    <= pxnAcc    | rspData[59];
      end
      if (strb.finish) begin
        doneLevel  <= lvl;
        if (kind == KIND_BAD)  doneFault <= FLT_XLAT;
        else if (!rspData[10]) doneFault <= FLT_ACCESS;
        else                   doneFault <= FLT_NONE;
        donePa     <= leafPa;
        doneSize   <= offW;
        doneXn     <= xnAcc  | rspData[54];
        donePxn    <= pxnAcc | rspData[53];
        doneRo     <= roAcc  | rspData[7];
        doneUser   <= rspData[6] & ~noUserAcc;
        doneNs     <= nsAcc  | rspData[5];
        doneNg     <= rspData[11];
        doneAttr   <= rspData[4:2];
        doneSh     <= rspData[9:8];
        doneContig <= rspData[52];
      end
    end
  end

  AST_NO_TABLE_AT_L3: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (lvl != 2'd3));                                // R3
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (doneFault != FLT_NONE) || doneSize == 5'd12 || doneSize == 5'd16 ||
                    doneSize == 5'd21 || doneSize == 5'd29 || doneSize == 5'd30); // R5
  AST_LIMIT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.start && xnAcc && roAcc) |=> (xnAcc && roAcc));       // R7
  AST_NS_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && nsAcc) |=> doneNs);                          // R8
  AST_BAD_START: assert property (@(posedge clk) disable iff (!rstN)
    (strb.start && startBad) |=> (doneFault == FLT_XLAT && doneLevel == 2'd0)); // R11
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VAW = VA_W,
  parameter int PAW = PA_W,
  parameter int DW  = DESC_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  output logic           reqReady,
  input  logic [VAW-1:0] reqVa,
  input  logic [1:0]     reqLevel,
  input  logic [PAW-1:0] reqBase,
  input  logic           reqGran64,
  output logic           memValid,
  input  logic           memReady,
  output logic [PAW-1:0] memAddr,
  input  logic           rspValid,
  input  logic [DW-1:0]  rspData,
  output logic           doneValid,
  output logic [PAW-1:0] donePa,
  output logic [4:0]     doneSize,
  output logic [1:0]     doneLevel,
  output logic [1:0]     doneFault,
  output logic           doneXn,
  output logic           donePxn,
  output logic           doneRo,
  output logic           doneUser,
  output logic           doneNs,
  output logic           doneNg,
  output logic [2:0]     doneAttr,
  output logic [1:0]     doneSh,
  output logic           doneContig
);
  strobe_t   strb;
  descKind_t kind;
  logic      startBad;

  xlat_ctrl uCtrl (
    .clk, .rstN, .reqValid, .startBad, .memReady, .rspValid, .kind,
    .strb, .reqReady, .memValid, .doneValid
  );

  xlat_dpath #(.VAW(VAW), .PAW(PAW), .DW(DW)) uDp (
    .clk, .rstN, .strb, .reqVa, .reqLevel, .reqBase, .reqGran64, .rspData,
    .startBad, .kind, .memAddr, .donePa, .doneSize, .doneLevel, .doneFault,
    .doneXn, .donePxn, .doneRo, .doneUser, .doneNs, .doneNg, .doneAttr,
    .doneSh, .doneContig
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> $stable(memAddr));               // R1
endmodule

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        reqValid = 1'b0, reqGran64 = 1'b0;
  logic        reqReady, memValid, doneValid;
  logic [47:0] reqVa = '0, reqBase = '0;
  logic [1:0]  reqLevel = '0;
  logic        memReady, rspValid;
  logic [47:0] memAddr, donePa;
  logic [63:0] rspData;
  logic [4:0]  doneSize;
  logic [1:0]  doneLevel, doneFault, doneSh;
  logic        doneXn, donePxn, doneRo, doneUser, doneNs, doneNg, doneContig;
  logic [2:0]  doneAttr;

  xlat_walker u0 (.*);

  int total = 0, bad = 0, nReads = 0;
  logic [47:0] mA[20];
  logic [63:0] mD[20];
  int nEnt = 0;
  logic [47:0] rdA;

  // captured result
  logic [47:0] rPa;
  logic [4:0]  rSize;
  logic [1:0]  rLvl, rFlt, rSh;
  logic        rXn, rPxn, rRo, rUser, rNs, rNg, rContig;
  logic [2:0]  rAttr;

  localparam logic [47:0] T0 = 48'h0000_1000_0000, T1 = 48'h0000_1000_1000;
  localparam logic [47:0] T2 = 48'h0000_1000_2000, T3 = 48'h0000_1000_3000;
  localparam logic [47:0] T2B = 48'h0000_1000_4000, T1B = 48'h0000_1000_5000;
  localparam logic [47:0] G0 = 48'h0000_2000_0000, G1 = 48'h0000_2001_0000;
  localparam logic [47:0] G2 = 48'h0000_2002_0000;

  function automatic logic [47:0] va4k(input logic [8:0] i0, i1, i2, i3, input logic [11:0] off);
    return {i0, i1, i2, i3, off};
  endfunction
  function automatic logic [47:0] va64(input logic [5:0] i1, input logic [12:0] i2, i3,
                                       input logic [15:0] off);
    return {i1, i2, i3, off};
  endfunction
  // table descriptor: flags = {bit63,bit62,bit61,bit60,bit59}
  function automatic logic [63:0] tbl(input logic [47:0] nb, input logic [4:0] fl);
    return {fl, 11'd0, nb} | 64'h3;
  endfunction

  task automatic put(input logic [47:0] a, input logic [63:0] d);
    mA[nEnt] = a; mD[nEnt] = d; nEnt++;
  endtask

  function automatic logic [63:0] lookup(input logic [47:0] a);
    for (int i = 0; i < nEnt; i++) if (mA[i] == a) return mD[i];
    return 64'd0;
  endfunction

  // memory responder
  initial begin
    memReady = 1'b0; rspValid = 1'b0; rspData = '0;
    forever begin
      @(negedge clk);
      if (rstN && memValid) begin
        memReady = 1'b1; rdA = memAddr;
        @(negedge clk);
        memReady = 1'b0; nReads++;
        rspData = lookup(rdA); rspValid = 1'b1;
        @(negedge clk);
        rspValid = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic walk(input logic [47:0] va, input logic [1:0] l, input logic [47:0] base,
                      input logic g64);
    int n = 0;
    nReads = 0;
    reqVa = va; reqLevel = l; reqBase = base; reqGran64 = g64; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1", "reqReady low while busy", reqReady, 0);
    while (!doneValid && n < 100) begin @(negedge clk); n++; end
    chk("R1", "walk completed", n < 100, 1);
    rPa = donePa; rSize = doneSize; rLvl = doneLevel; rFlt = doneFault; rSh = doneSh;
    rXn = doneXn; rPxn = donePxn; rRo = doneRo; rUser = doneUser; rNs = doneNs;
    rNg = doneNg; rContig = doneContig; rAttr = doneAttr;
    @(negedge clk);
    chk("R1", "doneValid single cycle", doneValid, 0);
  endtask

  task automatic expectLeaf(input string req, input logic [47:0] pa, input logic [4:0] sz,
                            input logic [1:0] l, input int reads);
    chk(req, "fault", rFlt, 0);
    chk(req, "pa", rPa, pa);
    chk(req, "size", rSize, sz);
    chk(req, "level", rLvl, l);
    chk("R1", "read count", reads, nReads);
  endtask

  task automatic expectFault(input string req, input logic [1:0] code, input logic [1:0] l,
                             input int reads);
    chk(req, "fault code", rFlt, code);
    chk(req, "fault level", rLvl, l);
    chk("R1", "read count", reads, nReads);
  endtask

  task automatic testReset();
    chk("R1", "reset reqReady", reqReady, 1);
    chk("R1", "reset memValid", memValid, 0);
    chk("R1", "reset doneValid", doneValid, 0);
  endtask

  // R2 R4 R5 R6: 4 KB four-level walk to a page
  task automatic testPage4k();
    walk(va4k(9'd5, 9'd7, 9'd9, 9'd11, 12'hABC), 2'd0, T0, 1'b0);
    expectLeaf("R2", 48'h0000_ABCD_EABC, 5'd12, 2'd3, 4);
    chk("R6", "attr index", rAttr, 3'b101);
    chk("R6", "shareability", rSh, 2'b10);
    chk("R6", "not global", rNg, 1);
    chk("R6", "contiguous", rContig, 1);
    chk("R7", "xn clean", rXn, 0);
    chk("R8", "ns clean", rNs, 0);
  endtask

  // R7 R8: level-1 table carrying every limit, then 2 MB block
  task automatic testLimits();
    walk(va4k(9'd0, 9'd3, 9'h055, 9'h1A2, 12'h345), 2'd1, T1, 1'b0);
    expectLeaf("R5", 48'h0000_407A_2345, 5'd21, 2'd2, 2);
    chk("R7", "xn inherited", rXn, 1);
    chk("R7", "pxn inherited", rPxn, 1);
    chk("R7", "ro inherited", rRo, 1);
    chk("R7", "user removed", rUser, 0);
    chk("R8", "ns forced", rNs, 1);
  endtask

  // R12 R5: 1 GB block after a restricted walk, leaf-only limits
  task automatic testGiga();
    walk(va4k(9'd2, 9'd4, 9'h123, 9'h0F0, 12'hFED), 2'd0, T0, 1'b0);
    expectLeaf("R5", 48'h0001_646F_0FED, 5'd30, 2'd1, 2);
    chk("R12", "xn not carried", rXn, 0);
    chk("R12", "pxn not carried", rPxn, 0);
    chk("R7", "ro from leaf", rRo, 1);
    chk("R12", "user not blocked", rUser, 1);
    chk("R8", "ns from leaf", rNs, 1);
  endtask

  // R2 R4 R5: 64 KB granule three-level walk to a page
  task automatic testPage64k();
    walk(va64(6'd3, 13'd10, 13'd20, 16'h1234), 2'd1, G0, 1'b1);
    expectLeaf("R4", 48'h0000_7777_1234, 5'd16, 2'd3, 3);
    chk("R7", "xn from 64k table", rXn, 1);
  endtask

  task automatic testBlock64k();
    walk(va64(6'd0, 13'd11, 13'h0ABC, 16'h5678), 2'd2, G1, 1'b1);
    expectLeaf("R5", 48'h0000_6ABC_5678, 5'd29, 2'd2, 1);
  endtask

  // R3 R9: invalid encodings and illegal block levels
  task automatic testInvalid();
    walk(va4k(9'd0, 9'd0, 9'd9, 9'd12, 12'd0), 2'd2, T2, 1'b0);
    expectFault("R9", 2'd1, 2'd3, 2);
    walk(va4k(9'd0, 9'd0, 9'd9, 9'd13, 12'd0), 2'd2, T2, 1'b0);
    expectFault("R3", 2'd1, 2'd3, 2);
    walk(va4k(9'd6, 9'd0, 9'd0, 9'd0, 12'd0), 2'd0, T0, 1'b0);
    expectFault("R3", 2'd1, 2'd0, 1);
    walk(va64(6'd4, 13'd0, 13'd0, 16'd0), 2'd1, G0, 1'b1);
    expectFault("R3", 2'd1, 2'd1, 1);
    walk(va4k(9'd0, 9'd8, 9'd0, 9'd0, 12'd0), 2'd1, T1, 1'b0);
    expectFault("R9", 2'd1, 2'd1, 1);
  endtask

  task automatic testAccessFlag();
    walk(va4k(9'd0, 9'd0, 9'd20, 9'd0, 12'd0), 2'd2, T2, 1'b0);
    expectFault("R10", 2'd2, 2'd2, 1);
  endtask

  task automatic testBadStart();
    walk(va64(6'd3, 13'd10, 13'd20, 16'd0), 2'd0, G0, 1'b1);
    expectFault("R11", 2'd1, 2'd0, 0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // 4 KB page walk
    put(T0 + 5*8,  tbl(T1, 5'b00000));
    put(T1 + 7*8,  tbl(T2, 5'b00000));
    put(T2 + 9*8,  tbl(T3, 5'b00000));
    put(T3 + 11*8, 64'h0010_0000_ABCD_E000 | 64'h3 | 64'h400 | 64'h800 | 64'h200 | 64'h14);
    // limits: bits 63..59 all set on the level-1 table
    put(T1 + 3*8,  tbl(T2B, 5'b11111));
    put(T2B + 48'h55*8, 64'h0000_0000_4060_0000 | 64'h1 | 64'h400 | 64'h40);
    // 1 GB block, leaf ro (bit7), user (bit6), ns (bit5), AF
    put(T0 + 2*8,  tbl(T1B, 5'b00000));
    put(T1B + 4*8, 64'h0000_0001_4000_0000 | 64'h4E1);
    // 64 KB granule
    put(G0 + 3*8,  tbl(G1, 5'b00010));
    put(G1 + 10*8, tbl(G2, 5'b00000));
    put(G2 + 20*8, 64'h0000_0000_7777_0000 | 64'h403);
    put(G1 + 11*8, 64'h0000_0000_6000_0000 | 64'h401);
    // invalid cases
    put(T3 + 13*8, 64'h0000_0000_0020_0401);
    put(T0 + 6*8,  64'h0000_0000_0000_0401);
    put(G0 + 4*8,  64'h0000_0000_4000_0401);
    put(T1 + 8*8,  64'h0000_0000_0000_0402);
    // block with access flag clear
    put(T2 + 20*8, 64'h0000_0000_0020_0001);

    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPage4k();
    testLimits();
    testGiga();
    testPage64k();
    testBlock64k();
    testInvalid();
    testAccessFlag();
    testBadStart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule